// File: doc/BRIEF.md
# Scratchpad Memory Command Engine with One-Time-Programmable Register

This block is the byte-level memory function layer of a single-wire EEPROM slave. A byte receiver hands it command, address and data bytes, and a byte transmitter takes the bytes it returns. The receiver and transmitter move each byte bit 0 first. A bus-reset strobe from the line layer ends whatever command is running. Bit timing, device selection and the programming delay of real EEPROM cells are handled elsewhere. Storage here is flip-flop arrays.

The engine has two storage areas. The first is a 32-byte data memory. The second is an 8-byte application register that can be programmed only once. Each area has its own scratchpad. The master fills a scratchpad with an auto-incrementing, wrapping address and can read it back. A validated copy command then moves the scratchpad into storage. The data memory accepts copies any number of times. The application register locks itself on its first copy, and an 8-bit status byte shows whether it has been locked.

Top module: `mce_engine`

## Requirements
- R1: After rst_n is released, tx_en is 0, every data memory and scratchpad byte reads 00h, and the status byte reads FFh.
- R2: Command 0Fh is write data scratchpad. The next byte is the start address, masked to its low 5 bits. Each later byte is stored at the current address, and the address then advances by one.
- R3: Command AAh reads the data scratchpad from a start address sent as the next byte. While tx_en is 1, tx_data holds the byte at the current address, and each tx_done pulse advances the address.
- R4: Addresses wrap. In the data areas the address goes from 1Fh to 00h. In the application areas, where the start address is masked to 3 bits, it goes from 7 to 0.
- R5: A write or read runs for any number of bytes until bus_reset. bus_reset returns the engine to waiting for a command byte, and the scratchpad contents are kept.
- R6: Command 55h followed by validation byte A5h copies all 32 data scratchpad bytes to data memory. Any other validation byte leaves the memory unchanged. Command F0h plus a start address reads the data memory the same way R3 reads the scratchpad.
- R7: Command 99h plus a start address writes the application scratchpad. Command C3h plus a start address reads the application scratchpad while the register is unlocked.
- R8: Command 5Ah followed by A5h copies the application scratchpad into the application register and clears status bits 1:0, so the status reads FCh. Once those bits are zero, further copies are ignored. From then on, C3h returns the locked register contents.
- R9: Command 66h returns the status byte on tx_data, with tx_en 1, until bus_reset.
- R10: Any unrecognised command byte makes the engine ignore all later bytes until bus_reset.
- R11: The data memory can be overwritten by repeated copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_reset | input | 1 | One-cycle strobe: the bus saw a reset pulse |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received command, address or data byte |
| tx_done | input | 1 | One-cycle strobe: transmitter has shipped tx_data |
| tx_en | output | 1 | Engine is supplying read bytes |
| tx_data | output | 8 | Byte to transmit (00h when tx_en is 0) |

## Verification
Assertions check on every cycle that:
- the address wraps to zero at the top of the selected area;
- a bus reset always lands the engine in the idle state;
- the wait-for-reset state is sticky;
- the data memory changes only on a copy strobe;
- a locked application register never changes;
- the status byte is only ever FFh or FCh.

Some behaviours can only be shown by the bench's directed scenarios, because each one depends on a specific sequence of bytes. These are:
- which address a masked start byte selects;
- the contents returned over long wrapping reads;
- rejection of a wrong validation byte;
- the scratchpad surviving a bus reset;
- a second lock attempt being refused.

// File: rtl/mce_pkg.sv
package mce_pkg;

  localparam logic [7:0] CMD_WR_SP   = 8'h0F;
  localparam logic [7:0] CMD_RD_SP   = 8'hAA;
  localparam logic [7:0] CMD_CP_SP   = 8'h55;
  localparam logic [7:0] CMD_RD_MEM  = 8'hF0;
  localparam logic [7:0] CMD_WR_AP   = 8'h99;
  localparam logic [7:0] CMD_RD_AP   = 8'hC3;
  localparam logic [7:0] CMD_LOCK_AP = 8'h5A;
  localparam logic [7:0] CMD_RD_STAT = 8'h66;
  localparam logic [7:0] VALIDATE    = 8'hA5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_VALID,
    ST_STATUS,
    ST_HALT
  } mce_state_t;

  // next address inside an area of 2**w bytes
  function automatic logic [7:0] wrap_inc(input logic [7:0] a, input int unsigned w);
    logic [7:0] m;
    m = 8'((16'd1 << w) - 16'd1);
    return (a + 8'd1) & m;
  endfunction

endpackage

// File: rtl/mce_ctrl.sv
module mce_ctrl
  import mce_pkg::*;
#(
  parameter int unsigned DAW = 5,
  parameter int unsigned AAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_reset,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           tx_done,
  output mce_state_t     state,
  output logic [7:0]     cmd,
  output logic [DAW-1:0] addr,
  output logic           ds_we,
  output logic           ap_we,
  output logic           ds_copy,
  output logic           ap_lock
);

  logic           is_app;
  int unsigned    aw_sel;
  logic [DAW-1:0] addr_top;
  logic [DAW-1:0] addr_next;
  logic           byte_in;

  assign is_app    = (cmd == CMD_WR_AP) || (cmd == CMD_RD_AP);
  assign aw_sel    = is_app ? AAW : DAW;
  assign addr_top  = is_app ? DAW'((1 << AAW) - 1) : DAW'((1 << DAW) - 1);
  assign addr_next = DAW'(wrap_inc(8'(addr), aw_sel));
  assign byte_in   = rx_valid && !bus_reset;

  assign ds_we   = (state == ST_WRITE) && byte_in && (cmd == CMD_WR_SP);
  assign ap_we   = (state == ST_WRITE) && byte_in && (cmd == CMD_WR_AP);
  assign ds_copy = (state == ST_VALID) && byte_in && (rx_byte == VALIDATE) && (cmd == CMD_CP_SP);
  assign ap_lock = (state == ST_VALID) && byte_in && (rx_byte == VALIDATE) && (cmd == CMD_LOCK_AP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd   <= 8'h00;
      addr  <= '0;
    end else if (bus_reset) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (rx_valid) begin
          cmd <= rx_byte;
          case (rx_byte)
            CMD_WR_SP, CMD_RD_SP, CMD_RD_MEM, CMD_WR_AP, CMD_RD_AP: state <= ST_ADDR;
            CMD_CP_SP, CMD_LOCK_AP: state <= ST_VALID;
            CMD_RD_STAT:            state <= ST_STATUS;
            default:                state <= ST_HALT;
          endcase
        end
        ST_ADDR: if (rx_valid) begin
          addr  <= is_app ? DAW'(rx_byte[AAW-1:0]) : rx_byte[DAW-1:0];
          state <= ((cmd == CMD_WR_SP) || (cmd == CMD_WR_AP)) ? ST_WRITE : ST_READ;
        end
        ST_WRITE: if (rx_valid) addr <= addr_next;
        ST_READ:  if (tx_done)  addr <= addr_next;
        ST_VALID: if (rx_valid) state <= ST_HALT;
        default: ;
      endcase
    end
  end

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && byte_in && addr == addr_top) |=> addr == '0);

  assert_bus_reset_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> state == ST_IDLE);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !bus_reset) |=> state == ST_HALT);

endmodule

// File: rtl/mce_data_store.sv
module mce_data_store #(
  parameter int unsigned DATA_BYTES = 32,
  parameter int unsigned DAW        = $clog2(DATA_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [DAW-1:0] addr,
  input  logic [7:0]     wdata,
  input  logic           copy,
  output logic [7:0]     rd_scratch,
  output logic [7:0]     rd_mem
);

  logic [DATA_BYTES-1:0][7:0] scratch;
  logic [DATA_BYTES-1:0][7:0] mem;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scratch[g] <= 8'h00;
        mem[g]     <= 8'h00;
      end else begin
        if (we && addr == DAW'(g)) scratch[g] <= wdata;
        if (copy)                  mem[g]     <= scratch[g];
      end
    end
  end

  assign rd_scratch = scratch[addr];
  assign rd_mem     = mem[addr];

  assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !copy |=> $stable(mem));

endmodule

// File: rtl/mce_app_store.sv
module mce_app_store #(
  parameter int unsigned APP_BYTES = 8,
  parameter int unsigned AAW       = $clog2(APP_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AAW-1:0] addr,
  input  logic [7:0]     wdata,
  input  logic           lock_req,
  output logic [7:0]     rd_byte,
  output logic [7:0]     status
);

  logic [APP_BYTES-1:0][7:0] scratch;
  logic [APP_BYTES-1:0][7:0] app_reg;
  logic                      unlocked;
  logic                      lock_fire;

  assign unlocked  = status[1:0] != 2'b00;
  assign lock_fire = lock_req && unlocked;

  for (genvar g = 0; g < APP_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scratch[g] <= 8'h00;
        app_reg[g] <= 8'h00;
      end else begin
        if (we && addr == AAW'(g)) scratch[g] <= wdata;
        if (lock_fire)             app_reg[g] <= scratch[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= 8'hFF;
    else if (lock_fire) status <= {status[7:2], 2'b00};
  end

  assign rd_byte = unlocked ? scratch[addr] : app_reg[addr];

  assert_otp_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] == 2'b00) |=> $stable(app_reg));

  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'hFF) || (status == 8'hFC));

endmodule

// File: rtl/mce_engine.sv
module mce_engine
  import mce_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 32,
  parameter int unsigned APP_BYTES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_done,
  output logic       tx_en,
  output logic [7:0] tx_data
);

  localparam int unsigned DAW = $clog2(DATA_BYTES);
  localparam int unsigned AAW = $clog2(APP_BYTES);

  mce_state_t     state;
  logic [7:0]     cmd;
  logic [DAW-1:0] addr;
  logic           ds_we, ap_we, ds_copy, ap_lock;
  logic [7:0]     rd_scratch, rd_mem, rd_app, status;
  logic [7:0]     rd_sel;

  mce_ctrl #(.DAW(DAW), .AAW(AAW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_done(tx_done),
    .state(state), .cmd(cmd), .addr(addr),
    .ds_we(ds_we), .ap_we(ap_we), .ds_copy(ds_copy), .ap_lock(ap_lock)
  );

  mce_data_store #(.DATA_BYTES(DATA_BYTES), .DAW(DAW)) u_data (
    .clk(clk), .rst_n(rst_n), .we(ds_we), .addr(addr), .wdata(rx_byte),
    .copy(ds_copy), .rd_scratch(rd_scratch), .rd_mem(rd_mem)
  );

  mce_app_store #(.APP_BYTES(APP_BYTES), .AAW(AAW)) u_app (
    .clk(clk), .rst_n(rst_n), .we(ap_we), .addr(addr[AAW-1:0]), .wdata(rx_byte),
    .lock_req(ap_lock), .rd_byte(rd_app), .status(status)
  );

  always_comb begin
    case (cmd)
      CMD_RD_SP:   rd_sel = rd_scratch;
      CMD_RD_MEM:  rd_sel = rd_mem;
      CMD_RD_AP:   rd_sel = rd_app;
      CMD_RD_STAT: rd_sel = status;
      default:     rd_sel = 8'h00;
    endcase
  end

  assign tx_en   = (state == ST_READ) || (state == ST_STATUS);
  assign tx_data = tx_en ? rd_sel : 8'h00;

endmodule

// File: tb/test_mce_engine.sv
module test_mce_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_done = 1'b0;
  logic       tx_en;
  logic [7:0] tx_data;

  int checks = 0;
  int fails  = 0;

  logic [7:0] sc [32];
  logic [7:0] mm [32];
  logic [7:0] asc [8];
  logic [7:0] areg [8];
  logic [7:0] stat;

  always #2.5 clk = ~clk;

  mce_engine i_mce_engine (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_done(tx_done), .tx_en(tx_en), .tx_data(tx_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic take(input string tag, input logic [7:0] exp);
    chk({tag, " tx_en"}, 8'(tx_en), 8'h01);
    chk(tag, tx_data, exp);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_en idle", 8'(tx_en), 8'h00);
    send(8'h66);
    take("R1 R9 status after reset", 8'hFF);
    breset();
    chk("R5 tx_en after bus reset", 8'(tx_en), 8'h00);
    send(8'hF0); send(8'h00);
    take("R1 memory cleared", 8'h00);
    breset();
    send(8'hAA); send(8'h09);
    take("R1 scratchpad cleared", 8'h00);
    breset();
  endtask

  task automatic t_write_read();
    send(8'h0F); send(8'h23);
    for (int i = 0; i < 4; i++) begin
      send(8'h10 + 8'(i)); sc[3 + i] = 8'h10 + 8'(i);
    end
    breset();
    send(8'hAA); send(8'h03);
    for (int i = 0; i < 4; i++) take("R2 R3 masked write readback", sc[3 + i]);
    breset();
  endtask

  task automatic t_wrap();
    send(8'h0F); send(8'h1E);
    send(8'hA1); sc[30] = 8'hA1;
    send(8'hA2); sc[31] = 8'hA2;
    send(8'hA3); sc[0]  = 8'hA3;
    breset();
    send(8'hAA); send(8'h1E);
    take("R4 byte 1E", 8'hA1);
    take("R4 byte 1F", 8'hA2);
    take("R4 wrap to 00", 8'hA3);
    breset();
  endtask

  task automatic t_long();
    send(8'h0F); send(8'h00);
    for (int i = 0; i < 40; i++) begin
      send(8'h40 + 8'(i)); sc[i % 32] = 8'h40 + 8'(i);
    end
    breset();
    send(8'hAA); send(8'h00);
    for (int i = 0; i < 40; i++) take("R5 long read", sc[i % 32]);
    breset();
    send(8'hAA); send(8'h05);
    take("R5 scratchpad kept over bus reset", sc[5]);
    breset();
  endtask

  task automatic t_copy();
    send(8'h55); send(8'h3C);
    breset();
    send(8'hF0); send(8'h05);
    take("R6 bad validation no copy", 8'h00);
    breset();
    send(8'h55); send(8'hA5);
    for (int i = 0; i < 32; i++) mm[i] = sc[i];
    breset();
    send(8'hF0); send(8'h00);
    for (int i = 0; i < 32; i++) take("R6 copied memory", mm[i]);
    breset();
    send(8'h0F); send(8'h05); send(8'hE7); sc[5] = 8'hE7;
    breset();
    send(8'h55); send(8'hA5);
    for (int i = 0; i < 32; i++) mm[i] = sc[i];
    breset();
    send(8'hF0); send(8'h05);
    take("R11 second copy", mm[5]);
    breset();
  endtask

  task automatic t_app();
    send(8'h99); send(8'h0A);
    for (int i = 0; i < 8; i++) begin
      send(8'hB0 + 8'(i)); asc[(2 + i) % 8] = 8'hB0 + 8'(i);
    end
    breset();
    send(8'hC3); send(8'h00);
    for (int i = 0; i < 9; i++) take("R7 R4 app scratchpad", asc[i % 8]);
    breset();
    send(8'h66);
    take("R9 status unlocked", stat);
    breset();
  endtask

  task automatic t_lock();
    send(8'h5A); send(8'hA5);
    if (stat[1:0] != 2'b00) begin
      for (int i = 0; i < 8; i++) areg[i] = asc[i];
      stat[1:0] = 2'b00;
    end
    breset();
    send(8'h66);
    take("R8 R9 status locked", stat);
    breset();
    send(8'h99); send(8'h00);
    for (int i = 0; i < 8; i++) begin
      send(8'h11 + 8'(i)); asc[i] = 8'h11 + 8'(i);
    end
    breset();
    send(8'h5A); send(8'hA5);
    breset();
    send(8'h66);
    take("R8 status after relock", 8'hFC);
    breset();
    send(8'hC3); send(8'h00);
    for (int i = 0; i < 8; i++) take("R8 locked register unchanged", areg[i]);
    breset();
  endtask

  task automatic t_halt();
    send(8'h12);
    chk("R10 tx_en in halt", 8'(tx_en), 8'h00);
    send(8'h0F); send(8'h00); send(8'h77);
    send(8'hAA);
    chk("R10 tx_en still quiet", 8'(tx_en), 8'h00);
    breset();
    send(8'hAA); send(8'h00);
    take("R10 ignored bytes", sc[0]);
    breset();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin sc[i] = 8'h00; mm[i] = 8'h00; end
    for (int i = 0; i < 8; i++) begin asc[i] = 8'h00; areg[i] = 8'h00; end
    stat = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap();
    t_long();
    t_copy();
    t_app();
    t_lock();
    t_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule